// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Decrement-and-Branch

This block is the control unit of a multicycle processor that shares a single memory between instructions and data. Each instruction takes several clock cycles. In every cycle the block drives the datapath control lines: memory read and write, the address source, the instruction-register load, the ALU operand selects, the ALU operation, the PC source, the PC write enables, the branch-target load, the register destination, the write-back source and the register write. It reads two inputs. The opcode comes from the instruction register, and the block consults it only in the decode cycle. The ALU zero flag is combined with the registered PC write enables to form a single PC load strobe.

The named states are FETCH, DECODE, MEM_ADDR, MEM_READ, MEM_WB, MEM_WRITE, R_EXEC, R_WB, BR_DONE, JMP_DONE and DBNZ_DONE. The transitions are as follows:
- FETCH always goes to DECODE.
- DECODE dispatches on the opcode class: to R_EXEC, to MEM_ADDR for loads and stores, to BR_DONE, to JMP_DONE or to DBNZ_DONE. An undefined opcode goes back to FETCH.
- MEM_ADDR goes to MEM_READ for a load and to MEM_WRITE for a store.
- MEM_READ goes to MEM_WB, and R_EXEC goes to R_WB.
- Every other state goes to FETCH.

The branch target (PC+4 plus the sign-extended displacement shifted left by 2) is computed in DECODE and loaded into a target register. Both the branch-if-equal completion and the decrement-and-branch completion reuse that register. The decrement-and-branch instruction stores a copy of its source register number in the second register field. It writes rs−1 back through that field and loads the PC only when the decremented value is non-zero.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: After reset and in every FETCH cycle, the outputs are mem_rd=1, iord=0, ir_wr=1, alu_sel_a=0, alu_sel_b=3'b001 (constant 4), alu_op=2'b00 (add), pc_src=2'b00 and pc_wr=1. Every control output not listed for a state in R1 to R10 is 0.
- R2: The cycle after FETCH is DECODE, with alu_sel_a=0, alu_sel_b=3'b011 (shifted displacement), alu_op=2'b00 and tgt_wr=1.
- R3: A decoded branch-if-equal opcode (6'b000100) leads to one cycle with alu_sel_a=1, alu_sel_b=3'b000 (register B), alu_op=2'b01 (subtract), pc_wr_cond=1 and pc_src=2'b01 (target register). FETCH follows.
- R4: A decoded jump opcode (6'b000010) leads to one cycle with pc_wr=1 and pc_src=2'b10. FETCH follows.
- R5: A decoded decrement-and-branch opcode (6'b010101) leads to one cycle with alu_sel_a=1, alu_sel_b=3'b100 (constant 1), alu_op=2'b01, reg_wr=1, reg_dst=0 (rt field), mem_to_reg=0, pc_wr_nz=1 and pc_src=2'b01. FETCH follows.
- R6: At most one of pc_wr, pc_wr_cond and pc_wr_nz is high in any cycle.
- R7: Any opcode other than 6'b000000, 6'b000010, 6'b000100, 6'b010101, 6'b100011 and 6'b101011 sends DECODE straight back to FETCH.
- R8: A load (6'b100011) runs three cycles and then FETCH. The cycles are: address (alu_sel_a=1, alu_sel_b=3'b010 sign-extended immediate, alu_op=2'b00); read (mem_rd=1, iord=1); write-back (reg_wr=1, reg_dst=0, mem_to_reg=1).
- R9: A store (6'b101011) runs the address cycle of R8, then a write cycle (mem_wr=1, iord=1), then FETCH.
- R10: A register-type opcode (6'b000000) runs two cycles and then FETCH. The cycles are: execute (alu_sel_a=1, alu_sel_b=3'b000, alu_op=2'b10 function field); write-back (reg_wr=1, reg_dst=1 rd field, mem_to_reg=0).
- R11: The opcode value has no effect outside the DECODE cycle. A value changed in any other cycle leaves the control sequence unchanged.
- R12: pc_load equals pc_wr OR (pc_wr_cond AND alu_zero) OR (pc_wr_nz AND NOT alu_zero).
- R13: None of reg_wr, mem_wr, ir_wr and tgt_wr is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| iord | output | 1 | Memory address source: 0 = PC, 1 = ALU output register |
| ir_wr | output | 1 | Instruction register load |
| alu_sel_a | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_sel_b | output | 3 | ALU operand B: 000 reg B, 001 const 4, 010 imm, 011 imm<<2, 100 const 1 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | 00 ALU result, 01 target register, 10 jump address |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when zero flag set |
| pc_wr_nz | output | 1 | PC write when zero flag clear |
| tgt_wr | output | 1 | Branch target register load |
| reg_dst | output | 1 | Destination field: 0 = rt, 1 = rd |
| mem_to_reg | output | 1 | Write-back source: 0 = ALU, 1 = memory data |
| reg_wr | output | 1 | Register file write |
| pc_load | output | 1 | Combined PC load strobe |

## Verification
The assertions assume that reset is released cleanly. They also assume the opcode carries a defined value during DECODE, because the undefined-opcode check reads the decoder's class in that cycle. The zero flag is taken to be meaningful only while a conditional PC enable is high. The stimulus changes opcode and alu_zero only on the falling edge. It holds a noise opcode in every cycle except DECODE, to show that the opcode is not consulted there. In the loop test a small counter model produces the zero flag from the decremented value, as a real datapath would.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W    = 6;
    localparam int SELB_W  = 3;
    localparam int AOP_W   = 2;
    localparam int PSRC_W  = 2;
    localparam int STATE_W = 4;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_DBNZ  = 6'b010101;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

    localparam logic [SELB_W-1:0] SELB_REG  = 3'b000;
    localparam logic [SELB_W-1:0] SELB_FOUR = 3'b001;
    localparam logic [SELB_W-1:0] SELB_IMM  = 3'b010;
    localparam logic [SELB_W-1:0] SELB_BOFS = 3'b011;
    localparam logic [SELB_W-1:0] SELB_ONE  = 3'b100;

    localparam logic [AOP_W-1:0] AOP_ADD   = 2'b00;
    localparam logic [AOP_W-1:0] AOP_SUB   = 2'b01;
    localparam logic [AOP_W-1:0] AOP_FUNCT = 2'b10;

    localparam logic [PSRC_W-1:0] PSRC_ALU  = 2'b00;
    localparam logic [PSRC_W-1:0] PSRC_TGT  = 2'b01;
    localparam logic [PSRC_W-1:0] PSRC_JUMP = 2'b10;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_MEM_ADDR  = 4'd2,
        ST_MEM_READ  = 4'd3,
        ST_MEM_WB    = 4'd4,
        ST_MEM_WRITE = 4'd5,
        ST_R_EXEC    = 4'd6,
        ST_R_WB      = 4'd7,
        ST_BR_DONE   = 4'd8,
        ST_JMP_DONE  = 4'd9,
        ST_DBNZ_DONE = 4'd10
    } state_t;

    typedef enum logic [2:0] {
        CL_RTYPE,
        CL_LOAD,
        CL_STORE,
        CL_BEQ,
        CL_JUMP,
        CL_DBNZ,
        CL_BAD
    } op_class_t;

    typedef struct packed {
        logic              mem_rd;
        logic              mem_wr;
        logic              iord;
        logic              ir_wr;
        logic              sel_a;
        logic [SELB_W-1:0] sel_b;
        logic [AOP_W-1:0]  aop;
        logic [PSRC_W-1:0] psrc;
        logic              pc_wr;
        logic              pc_wr_cond;
        logic              pc_wr_nz;
        logic              tgt_wr;
        logic              reg_dst;
        logic              mem_to_reg;
        logic              reg_wr;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

    function automatic ctrl_t ctrl_of(input state_t st);
        ctrl_t c;
        c = CTRL_IDLE;
        unique case (st)
            ST_FETCH: begin
                c.mem_rd = 1'b1;
                c.ir_wr  = 1'b1;
                c.sel_b  = SELB_FOUR;
                c.aop    = AOP_ADD;
                c.psrc   = PSRC_ALU;
                c.pc_wr  = 1'b1;
            end
            ST_DECODE: begin
                c.sel_b  = SELB_BOFS;
                c.aop    = AOP_ADD;
                c.tgt_wr = 1'b1;
            end
            ST_MEM_ADDR: begin
                c.sel_a = 1'b1;
                c.sel_b = SELB_IMM;
                c.aop   = AOP_ADD;
            end
            ST_MEM_READ: begin
                c.mem_rd = 1'b1;
                c.iord   = 1'b1;
            end
            ST_MEM_WB: begin
                c.reg_wr     = 1'b1;
                c.mem_to_reg = 1'b1;
            end
            ST_MEM_WRITE: begin
                c.mem_wr = 1'b1;
                c.iord   = 1'b1;
            end
            ST_R_EXEC: begin
                c.sel_a = 1'b1;
                c.sel_b = SELB_REG;
                c.aop   = AOP_FUNCT;
            end
            ST_R_WB: begin
                c.reg_wr  = 1'b1;
                c.reg_dst = 1'b1;
            end
            ST_BR_DONE: begin
                c.sel_a      = 1'b1;
                c.sel_b      = SELB_REG;
                c.aop        = AOP_SUB;
                c.pc_wr_cond = 1'b1;
                c.psrc       = PSRC_TGT;
            end
            ST_JMP_DONE: begin
                c.pc_wr = 1'b1;
                c.psrc  = PSRC_JUMP;
            end
            ST_DBNZ_DONE: begin
                c.sel_a    = 1'b1;
                c.sel_b    = SELB_ONE;
                c.aop      = AOP_SUB;
                c.reg_wr   = 1'b1;
                c.reg_dst  = 1'b0;
                c.pc_wr_nz = 1'b1;
                c.psrc     = PSRC_TGT;
            end
            default: c = CTRL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mc_op_decode.sv
module mc_op_decode
    import mc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_class_t       op_class
);

    always_comb begin
        unique case (opcode)
            OPC_RTYPE: op_class = CL_RTYPE;
            OPC_LOAD:  op_class = CL_LOAD;
            OPC_STORE: op_class = CL_STORE;
            OPC_BEQ:   op_class = CL_BEQ;
            OPC_JUMP:  op_class = CL_JUMP;
            OPC_DBNZ:  op_class = CL_DBNZ;
            default:   op_class = CL_BAD;
        endcase
    end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_t    state_q,
    input  op_class_t live_class,
    input  op_class_t held_class,
    output state_t    state_d
);

    always_comb begin
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (live_class)
                    CL_RTYPE: state_d = ST_R_EXEC;
                    CL_LOAD:  state_d = ST_MEM_ADDR;
                    CL_STORE: state_d = ST_MEM_ADDR;
                    CL_BEQ:   state_d = ST_BR_DONE;
                    CL_JUMP:  state_d = ST_JMP_DONE;
                    CL_DBNZ:  state_d = ST_DBNZ_DONE;
                    default:  state_d = ST_FETCH;
                endcase
            end
            ST_MEM_ADDR: state_d = (held_class == CL_STORE) ? ST_MEM_WRITE : ST_MEM_READ;
            ST_MEM_READ: state_d = ST_MEM_WB;
            ST_R_EXEC:   state_d = ST_R_WB;
            default:     state_d = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_encode.sv
module mc_ctrl_encode
    import mc_ctrl_pkg::*;
(
    input  state_t st,
    output ctrl_t  ctrl
);

    always_comb ctrl = ctrl_of(st);

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic              alu_zero,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              iord,
    output logic              ir_wr,
    output logic              alu_sel_a,
    output logic [SELB_W-1:0] alu_sel_b,
    output logic [AOP_W-1:0]  alu_op,
    output logic [PSRC_W-1:0] pc_src,
    output logic              pc_wr,
    output logic              pc_wr_cond,
    output logic              pc_wr_nz,
    output logic              tgt_wr,
    output logic              reg_dst,
    output logic              mem_to_reg,
    output logic              reg_wr,
    output logic              pc_load
);

    state_t    state_q;
    state_t    state_d;
    op_class_t live_class;
    op_class_t held_class;
    ctrl_t     ctrl_d;
    ctrl_t     ctrl_q;

    mc_op_decode u_dec (
        .opcode   (opcode),
        .op_class (live_class)
    );

    mc_next_state u_nxt (
        .state_q    (state_q),
        .live_class (live_class),
        .held_class (held_class),
        .state_d    (state_d)
    );

    mc_ctrl_encode u_enc (
        .st   (state_d),
        .ctrl (ctrl_d)
    );

    // state register, registered Moore outputs and class latched at decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_FETCH;
            ctrl_q     <= ctrl_of(ST_FETCH);
            held_class <= CL_BAD;
        end else begin
            state_q <= state_d;
            ctrl_q  <= ctrl_d;
            if (state_q == ST_DECODE) held_class <= live_class;
        end
    end

    always_comb begin
        mem_rd     = ctrl_q.mem_rd;
        mem_wr     = ctrl_q.mem_wr;
        iord       = ctrl_q.iord;
        ir_wr      = ctrl_q.ir_wr;
        alu_sel_a  = ctrl_q.sel_a;
        alu_sel_b  = ctrl_q.sel_b;
        alu_op     = ctrl_q.aop;
        pc_src     = ctrl_q.psrc;
        pc_wr      = ctrl_q.pc_wr;
        pc_wr_cond = ctrl_q.pc_wr_cond;
        pc_wr_nz   = ctrl_q.pc_wr_nz;
        tgt_wr     = ctrl_q.tgt_wr;
        reg_dst    = ctrl_q.reg_dst;
        mem_to_reg = ctrl_q.mem_to_reg;
        reg_wr     = ctrl_q.reg_wr;
        pc_load    = ctrl_q.pc_wr | (ctrl_q.pc_wr_cond & alu_zero)
                   | (ctrl_q.pc_wr_nz & ~alu_zero);
    end

    // R6
    pc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pc_wr, pc_wr_cond, pc_wr_nz}) <= 1);

    // R2
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (tgt_wr && !alu_sel_a && alu_sel_b == SELB_BOFS));

    // R3 R4 R5
    done_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_cond || pc_wr_nz || (pc_wr && !ir_wr)) |=> (ir_wr && mem_rd && pc_wr));

    // R5
    dbnz_write_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_nz |-> (reg_wr && !reg_dst && !mem_to_reg && alu_sel_b == SELB_ONE));

    // R7
    bad_op_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr && live_class == CL_BAD) |=> ir_wr);

    // R13
    reg_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R13
    mem_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R13
    ir_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> !ir_wr);

    // R13
    tgt_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |=> !tgt_wr);

endmodule

// File: tb/mc_ctrl_fsm_tb_top.sv
module mc_ctrl_fsm_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'b111111;
    logic       alu_zero = 1'b0;
    logic       mem_rd, mem_wr, iord, ir_wr, alu_sel_a;
    logic [2:0] alu_sel_b;
    logic [1:0] alu_op, pc_src;
    logic       pc_wr, pc_wr_cond, pc_wr_nz, tgt_wr, reg_dst, mem_to_reg, reg_wr, pc_load;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mc_ctrl_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .iord(iord), .ir_wr(ir_wr),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .alu_op(alu_op),
        .pc_src(pc_src), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .pc_wr_nz(pc_wr_nz), .tgt_wr(tgt_wr), .reg_dst(reg_dst),
        .mem_to_reg(mem_to_reg), .reg_wr(reg_wr), .pc_load(pc_load)
    );

    function automatic logic [18:0] cv(input logic mrd, mwr, iod, irw, sa,
                                       input logic [2:0] sb, input logic [1:0] op,
                                       input logic [1:0] ps, input logic pw, pwc, pwn,
                                       input logic tw, rd, m2r, rw);
        return {mrd, mwr, iod, irw, sa, sb, op, ps, pw, pwc, pwn, tw, rd, m2r, rw};
    endfunction

    logic [18:0] E_FETCH, E_DEC, E_ADDR, E_READ, E_LWB, E_WRITE, E_REX, E_RWB, E_BEQ, E_JMP, E_DBNZ;
    initial begin
        E_FETCH = cv(1,0,0,1,0,3'b001,2'b00,2'b00,1,0,0,0,0,0,0);
        E_DEC   = cv(0,0,0,0,0,3'b011,2'b00,2'b00,0,0,0,1,0,0,0);
        E_ADDR  = cv(0,0,0,0,1,3'b010,2'b00,2'b00,0,0,0,0,0,0,0);
        E_READ  = cv(1,0,1,0,0,3'b000,2'b00,2'b00,0,0,0,0,0,0,0);
        E_LWB   = cv(0,0,0,0,0,3'b000,2'b00,2'b00,0,0,0,0,0,1,1);
        E_WRITE = cv(0,1,1,0,0,3'b000,2'b00,2'b00,0,0,0,0,0,0,0);
        E_REX   = cv(0,0,0,0,1,3'b000,2'b10,2'b00,0,0,0,0,0,0,0);
        E_RWB   = cv(0,0,0,0,0,3'b000,2'b00,2'b00,0,0,0,0,1,0,1);
        E_BEQ   = cv(0,0,0,0,1,3'b000,2'b01,2'b01,0,1,0,0,0,0,0);
        E_JMP   = cv(0,0,0,0,0,3'b000,2'b00,2'b10,1,0,0,0,0,0,0);
        E_DBNZ  = cv(0,0,0,0,1,3'b100,2'b01,2'b01,0,0,1,0,0,0,1);
    end

    function automatic logic [18:0] got();
        return {mem_rd, mem_wr, iord, ir_wr, alu_sel_a, alu_sel_b, alu_op, pc_src,
                pc_wr, pc_wr_cond, pc_wr_nz, tgt_wr, reg_dst, mem_to_reg, reg_wr};
    endfunction

    task automatic chk_vec(input logic [18:0] exp, input string req);
        n_chk++;
        if (got() !== exp) begin
            n_bad++;
            $display("FAIL %s: controls actual=%b expected=%b", req, got(), exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // common head: at a negedge in FETCH; opcode valid only during DECODE
    task automatic to_decode(input logic [5:0] op, input logic [5:0] noise);
        opcode = noise;
        @(negedge clk);
        chk_vec(E_DEC, "R2 decode");
        opcode = op;
        @(negedge clk);
        opcode = noise;
    endtask

    task automatic t_beq(input logic z);
        to_decode(6'b000100, 6'b000010);
        chk_vec(E_BEQ, "R3 branch completion");
        alu_zero = z; #1;
        chk_bit(pc_load, z, "R12 branch pc_load");
        @(negedge clk);
        chk_vec(E_FETCH, "R3 back to fetch");
    endtask

    task automatic t_jump();
        to_decode(6'b000010, 6'b000100);
        chk_vec(E_JMP, "R4 jump completion");
        chk_bit(pc_wr & pc_wr_cond, 1'b0, "R6 single pc enable");
        @(negedge clk);
        chk_vec(E_FETCH, "R4 back to fetch");
    endtask

    task automatic t_load();
        to_decode(6'b100011, 6'b101011);
        chk_vec(E_ADDR, "R8 address");
        @(negedge clk);
        chk_vec(E_READ, "R8 read");
        @(negedge clk);
        chk_vec(E_LWB, "R8 write-back");
        @(negedge clk);
        chk_vec(E_FETCH, "R8 back to fetch");
    endtask

    task automatic t_store();
        to_decode(6'b101011, 6'b100011);
        chk_vec(E_ADDR, "R9 address");
        @(negedge clk);
        chk_vec(E_WRITE, "R9 write");
        @(negedge clk);
        chk_vec(E_FETCH, "R9 back to fetch");
    endtask

    task automatic t_rtype();
        to_decode(6'b000000, 6'b010101);
        chk_vec(E_REX, "R10 execute");
        @(negedge clk);
        chk_vec(E_RWB, "R10 write-back rd");
        @(negedge clk);
        chk_vec(E_FETCH, "R10 back to fetch");
    endtask

    task automatic t_bad(input logic [5:0] op);
        to_decode(op, 6'b000100);
        chk_vec(E_FETCH, "R7 undefined opcode returns to fetch");
        chk_bit(reg_wr | mem_wr, 1'b0, "R7 no write after undefined opcode");
    endtask

    // stub register file entry: counter decremented on each DBNZ write
    task automatic t_dbnz_loop(input int start);
        int cnt = start;
        for (int pass = 0; pass < start; pass++) begin
            to_decode(6'b010101, 6'b000000);
            chk_vec(E_DBNZ, "R5 dbnz completion");
            alu_zero = ((cnt - 1) == 0); #1;
            chk_bit(pc_load, (cnt - 1) != 0, "R5 R12 dbnz branch only on non-zero");
            if (reg_wr) cnt = cnt - 1;
            @(negedge clk);
            chk_vec(E_FETCH, "R5 back to fetch");
        end
        n_chk++;
        if (cnt != 0) begin
            n_bad++;
            $display("FAIL R5: loop counter actual=%0d expected=0", cnt);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;
        chk_vec(E_FETCH, "R1 reset state");
        chk_bit(pc_load, 1'b1, "R12 fetch pc_load");
        t_beq(1'b1);
        t_beq(1'b0);
        t_jump();
        t_load();
        t_store();
        t_rtype();
        t_bad(6'b111111);
        t_bad(6'b001000);
        t_dbnz_loop(3);
        t_dbnz_loop(1);
        // R11: garbage opcode everywhere except decode leaves load sequence intact
        to_decode(6'b100011, 6'b101011);
        opcode = 6'b000010;
        chk_vec(E_ADDR, "R11 opcode ignored after decode");
        @(negedge clk);
        opcode = 6'b101011;
        chk_vec(E_READ, "R11 held load class");
        @(negedge clk);
        chk_vec(E_LWB, "R11 write-back");
        @(negedge clk);
        chk_vec(E_FETCH, "R11 fetch");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule